// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is a serial flash host engine driven from a byte-wide register bus. Software programs a command byte and a packed pair of byte counts, loads outgoing data through a single data port into a small shared buffer, and then sets a start bit. The engine pulls chip select low and clocks out the command byte, followed by the outgoing bytes taken from the buffer. It then clocks in the requested number of incoming bytes. Each incoming byte is stored in the buffer directly behind the outgoing ones. When the last bit has been received, chip select is released.

The buffer has eight entries and a single access pointer. Software can read that pointer, and it can reset the pointer to zero. To reach the received bytes after a command, software resets the pointer, then reads and discards as many bytes as it sent. The sequencer is a four-state machine:
- ST_IDLE moves to ST_LAUNCH on a start request.
- ST_LAUNCH starts one byte on the shifter and moves to ST_SHIFT.
- ST_SHIFT waits for the byte to finish. It returns to ST_LAUNCH when more bytes remain, or moves to ST_CLOSE after the last byte.
- ST_CLOSE releases chip select and returns to ST_IDLE.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the status busy bit (offset 0x3, bit 7) reads 0 and the pointer readback (offset 0xD, bits 2:0) reads 0.
- R2: The command byte register sits at offset 0x0 and the count register at offset 0x1; both read back what was written. The count register holds the receive count in bits 7:4 and the transmit count in bits 3:0.
- R3: Each command starts with the command register byte on the wire, never a buffer entry. Bits are sent MSB first in SPI mode 0: the clock idles low, the data line is stable at each rising edge, and the clock period is 4 system clocks.
- R4: The outgoing bytes follow the command byte in buffer order, from entry 0 up to entry count-1.
- R5: Incoming byte j is sampled on rising edges and stored in buffer entry (tx_count + j) mod 8. The data line is driven to 0 while incoming bytes are clocked.
- R6: Every read or write of the data port (offset 0xC) moves the pointer forward by one, modulo 8. A read returns the entry at the pointer.
- R7: Writing 1 to control bit 4 (offset 0x2) sets the pointer to 0.
- R8: Writing 1 to control bit 0 starts a command. This bit reads 1 while the command runs and returns to 0 by itself when the command ends.
- R9: Status bit 7 reads 1 for the whole time a command is in progress.
- R10: Chip select stays low across exactly 8*(1+tx+rx) rising clock edges and is high again when the command ends.
- R11: While a command runs, writes to the command register, the count register and the data port change nothing, and a data-port write does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (moves the pointer on the data port) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets five corner cases:
- A command with no outgoing bytes. A design that takes the first wire byte from the buffer would send entry 0 instead of the command byte.
- A command whose incoming bytes run past entry 7. A design that does not wrap would lose bytes or write past the end, and the readback of the overwritten low entries would be wrong.
- Register writes issued in the middle of a command. A leaky design would change the command or count readback, or corrupt entry 0.
- Pointer wraparound after eight reads, which catches a pointer that saturates or is too wide.
- The number of clock edges under chip select and their spacing. These expose an off-by-one byte count or a wrong divider.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int DATA_W = 8;

    // register offsets decoded on the byte bus
    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNTS = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_STATUS = 4'h3;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_PTR    = 4'hD;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 4;
    localparam int STAT_BUSY_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_SHIFT  = 2'd2,
        ST_CLOSE  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic          sw_rd,
    input  logic [DW-1:0] sw_wdata,
    input  logic          ptr_clr,
    input  logic          eng_wr,
    input  logic [PW-1:0] eng_idx,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] sw_rdata,
    output logic [DW-1:0] eng_rdata,
    output logic [PW-1:0] ptr
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (ptr_clr)
                ptr <= '0;
            else if (sw_wr || sw_rd)
                ptr <= ptr + 1'b1;
            if (sw_wr)
                mem[ptr] <= sw_wdata;
            if (eng_wr)
                mem[eng_idx] <= eng_wdata;
        end
    end

    assign sw_rdata  = mem[ptr];
    assign eng_rdata = mem[eng_idx];

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int CLK_DIV = 4,
    parameter int DW      = 8,
    localparam int PH_W   = $clog2(CLK_DIV),
    localparam int BC_W   = $clog2(DW),
    localparam int HALF   = CLK_DIV / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    input  logic          miso,
    output logic          mosi,
    output logic          sclk,
    output logic          active,
    output logic          done,
    output logic [DW-1:0] rx_byte
);

    logic [PH_W-1:0] ph;
    logic [BC_W-1:0] bitc;
    logic [DW-1:0]   tx_sh;
    logic [DW-1:0]   rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            ph     <= '0;
            bitc   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                ph     <= '0;
                bitc   <= '0;
                tx_sh  <= tx_byte;
            end else if (active) begin
                ph <= ph + 1'b1;
                // rising edge of sclk follows this cycle: capture input
                if (ph == PH_W'(HALF - 1))
                    rx_sh <= {rx_sh[DW-2:0], miso};
                if (ph == PH_W'(CLK_DIV - 1)) begin
                    ph    <= '0;
                    tx_sh <= tx_sh << 1;
                    if (bitc == BC_W'(DW - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitc <= bitc + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi    = tx_sh[DW-1];
    assign sclk    = active && (ph >= PH_W'(HALF));
    assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int CNT_W = DATA_W / 2;
    localparam int NUM_W = CNT_W + 2;

    eng_state_t        state_q, state_d;
    logic [NUM_W-1:0]  byte_no_q, byte_no_d;
    logic [DATA_W-1:0] opcode_q, counts_q;
    logic              busy;

    logic [NUM_W-1:0]  tx_cnt, rx_cnt, prev_no;
    logic              last_byte, in_rx;
    logic              go, sw_fifo_wr, sw_fifo_rd, ptr_clr;

    logic [PTR_W-1:0]  eng_idx, fifo_ptr;
    logic [DATA_W-1:0] fifo_sw_rdata, fifo_eng_rdata;
    logic              eng_wr, sh_start, sh_active, sh_done;
    logic [DATA_W-1:0] sh_tx, sh_rx;

    assign busy       = (state_q != ST_IDLE);
    assign tx_cnt     = NUM_W'(counts_q[CNT_W-1:0]);
    assign rx_cnt     = NUM_W'(counts_q[2*CNT_W-1:CNT_W]);
    assign last_byte  = (byte_no_q == tx_cnt + rx_cnt);
    assign in_rx      = (byte_no_q > tx_cnt);
    assign prev_no    = byte_no_q - 1'b1;
    assign eng_idx    = prev_no[PTR_W-1:0];

    assign go         = bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_GO_BIT] && !busy;
    assign ptr_clr    = bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_CLR_BIT];
    assign sw_fifo_wr = bus_wr && bus_addr == OFS_DATA && !busy;
    assign sw_fifo_rd = bus_rd && bus_addr == OFS_DATA;

    // configuration registers, frozen while a command runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= '0;
            counts_q <= '0;
        end else if (bus_wr && !busy) begin
            if (bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
            if (bus_addr == OFS_COUNTS) counts_q <= bus_wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            byte_no_q <= '0;
        end else begin
            state_q   <= state_d;
            byte_no_q <= byte_no_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        byte_no_d = byte_no_q;
        unique case (state_q)
            ST_IDLE: if (go) begin
                state_d   = ST_LAUNCH;
                byte_no_d = '0;
            end
            ST_LAUNCH: state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) begin
                if (last_byte) begin
                    state_d = ST_CLOSE;
                end else begin
                    state_d   = ST_LAUNCH;
                    byte_no_d = byte_no_q + 1'b1;
                end
            end
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        sh_start = (state_q == ST_LAUNCH);
        spi_cs_n = !(state_q == ST_LAUNCH || state_q == ST_SHIFT);
        eng_wr   = (state_q == ST_SHIFT) && sh_done && in_rx;
        if (byte_no_q == '0)
            sh_tx = opcode_q;
        else if (!in_rx)
            sh_tx = fifo_eng_rdata;
        else
            sh_tx = '0;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_OPCODE: bus_rdata = opcode_q;
            OFS_COUNTS: bus_rdata = counts_q;
            OFS_CTRL:   bus_rdata = DATA_W'(busy);
            OFS_STATUS: bus_rdata = {busy, {(DATA_W-1){1'b0}}};
            OFS_DATA:   bus_rdata = fifo_sw_rdata;
            OFS_PTR:    bus_rdata = DATA_W'(fifo_ptr);
            default:    bus_rdata = '0;
        endcase
    end

    spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (sw_fifo_wr),
        .sw_rd     (sw_fifo_rd),
        .sw_wdata  (bus_wdata),
        .ptr_clr   (ptr_clr),
        .eng_wr    (eng_wr),
        .eng_idx   (eng_idx),
        .eng_wdata (sh_rx),
        .sw_rdata  (fifo_sw_rdata),
        .eng_rdata (fifo_eng_rdata),
        .ptr       (fifo_ptr)
    );

    spi_cmd_shifter #(.CLK_DIV(CLK_DIV), .DW(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .mosi    (spi_mosi),
        .sclk    (spi_sclk),
        .active  (sh_active),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             spi_cs_n,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             busy,
    input logic [7:0]       opcode_q,
    input logic [7:0]       counts_q,
    input logic [PTR_W-1:0] fifo_ptr
);

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3
    mosi_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));

    // R9
    busy_under_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R8
    release_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> spi_cs_n);

    // R11
    opcode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 4'h0) |=> $stable(opcode_q));

    // R11
    counts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == 4'h1) |=> $stable(counts_q));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 4'hC) |=> fifo_ptr == $past(fifo_ptr) + 1'b1);

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .busy     (busy),
    .opcode_q (opcode_q),
    .counts_q (counts_q),
    .fifo_ptr (fifo_ptr)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] resp_of(input int k);
        return 8'hC3 ^ 8'(k * 29);
    endfunction

    // ---------------- flash model and scoreboard monitor ----------------
    logic [7:0] exp_q[$];
    logic [2:0] sl_bit = '0;
    int         sl_byte = 0;
    logic [7:0] sl_cap = '0;
    int         sl_edges = 0;
    int         period_bad = 0;
    time        t_last = 0;
    logic [7:0] miso_byte;

    always_comb begin
        miso_byte = resp_of(sl_byte);
        spi_miso  = miso_byte[3'd7 - sl_bit];
    end

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            sl_bit  = '0;
            sl_byte = 0;
        end else begin
            if (sl_bit != 3'd0 && ($time - t_last) != 40) period_bad++;
            t_last = $time;
            sl_edges++;
            sl_cap = {sl_cap[6:0], spi_mosi};
            if (sl_bit == 3'd7) begin
                if (exp_q.size() == 0) begin
                    chk("R10 extra byte on wire", 1, 0);
                end else begin
                    // R3 R4 R5: opcode, then tx bytes, then zero fill
                    chk("R3/R4/R5 wire byte", sl_cap, exp_q.pop_front());
                end
                sl_byte++;
            end
            sl_bit = sl_bit + 3'd1;
        end
    end

    // ---------------- bus driver ----------------
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        do bus_read(4'h3, s); while (s[7]);
    endtask

    logic [7:0] model [8];

    task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                           input logic [7:0] seed, input bit poke);
        logic [7:0] d;
        int e0;
        bus_write(4'h1, 8'((rx << 4) | tx));
        bus_write(4'h0, op);
        bus_write(4'h2, 8'h10);
        for (int i = 0; i < tx; i++) begin
            model[i] = seed ^ 8'(i * 17);
            bus_write(4'hC, model[i]);
        end
        bus_read(4'hD, d);
        chk("R6 pointer after loads", d[2:0], tx % 8);
        bus_write(4'h2, 8'h10);
        bus_read(4'hD, d);
        chk("R7 pointer cleared", d[2:0], 0);
        exp_q.push_back(op);
        for (int i = 0; i < tx; i++) exp_q.push_back(model[i]);
        for (int i = 0; i < rx; i++) exp_q.push_back(8'h00);
        e0 = sl_edges;
        period_bad = 0;
        bus_write(4'h2, 8'h01);
        if (poke) begin
            bus_read(4'h3, d);
            chk("R9 busy while running", d[7], 1);
            bus_read(4'h2, d);
            chk("R8 start bit reads 1", d[0], 1);
            bus_write(4'h0, 8'h55);
            bus_write(4'h1, 8'h11);
            bus_write(4'hC, 8'hEE);
        end
        wait_idle();
        bus_read(4'h2, d);
        chk("R8 start bit self-clears", d[0], 0);
        chk("R10 cs high after", spi_cs_n, 1);
        chk("R10 edge count", sl_edges - e0, 8 * (1 + tx + rx));
        chk("R10 all bytes sent", exp_q.size(), 0);
        chk("R3 sclk period", period_bad, 0);
        bus_read(4'h0, d);
        chk("R2/R11 opcode readback", d, op);
        bus_read(4'h1, d);
        chk("R2/R11 count readback", d, (rx << 4) | tx);
        for (int j = 0; j < rx; j++) model[(tx + j) % 8] = resp_of(1 + tx + j);
        bus_write(4'h2, 8'h10);
        for (int i = 0; i < tx + rx && i < 8; i++) begin
            bus_read(4'hC, d);
            chk("R5/R11 buffer readback", d, model[i]);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", spi_cs_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        bus_read(4'h3, d);
        chk("R1 busy", d[7], 0);
        rst_n = 1'b1;
        bus_read(4'hD, d);
        chk("R1 pointer", d[2:0], 0);

        run_cmd(8'h9F, 0, 3, 8'h00, 1'b0);  // receive only: opcode never from buffer
        run_cmd(8'h03, 3, 4, 8'h12, 1'b1);  // writes during run ignored
        run_cmd(8'hA5, 6, 4, 8'h3C, 1'b0);  // receive data wraps past entry 7

        // R6 wraparound after eight reads, entries 0/1 from the wrapped receive
        bus_write(4'h2, 8'h10);
        for (int i = 0; i < 8; i++) bus_read(4'hC, d);
        bus_read(4'hC, d);
        chk("R6 wrapped read value", d, resp_of(9));
        bus_read(4'hD, d);
        chk("R6 pointer wrapped", d[2:0], 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule